// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Target

This block is a target on a two-wire serial bus (clock line and open-drain data line) that sits in front of a 256 x 8 byte store built from flip-flops. A fast system clock oversamples both bus lines. From these samples the block finds start and stop conditions, shifts bytes in and out, and answers each received byte by pulling the data line low. It keeps one word pointer that survives from one transaction to the next. With that pointer it serves single and multi-byte writes, reads from the current address, reads from a freshly loaded address, and sequential reads.

Every byte the block stores is also presented for one cycle on a byte-write strobe to a neighbouring page-write unit. That unit answers with a busy flag. While the flag is high the block refuses every device address, so a host can poll until the flag drops.

Top module: `twi_mem_target`

## Requirements
- R1: A transaction begins only at a start (data falls while the clock is high). A stop (data rises while the clock is high) returns the block to idle with the data line released. Bytes clocked without a preceding start get no acknowledge.
- R2: The first byte after a start is acknowledged only if its bits [7:4] are 1010 and its bits [3:1] equal `strap_i`. Bit 0 set to 1 selects a read and set to 0 selects a write. A byte that does not match gets no acknowledge, and the block then ignores the bus until the next start.
- R3: While `wr_busy_i` is high, no device address is acknowledged, even one that matches.
- R4: In a write, the byte after the device address loads the word pointer. Each following data byte is acknowledged, stored at the pointer, and presented for one cycle on `wr_valid_o` with `wr_addr_o` and `wr_data_o`.
- R5: After each stored byte the pointer's low 3 bits step by one and wrap inside the 8-byte page. The upper bits are unchanged.
- R6: Read data leaves MSB first. Each bit changes only while the clock is low. The block keeps sending the next byte while the host acknowledges. After a host non-acknowledge it releases the line and waits for a stop or start.
- R7: During reads the pointer advances by one after each byte and wraps from 255 to 0.
- R8: The pointer keeps the last accessed address plus one across transactions. A read with no address phase returns data from that address.
- R9: A write that carries only the word address, followed by a repeated start and a read, returns data starting at the loaded address.
- R10: After reset the data line is released, `wr_valid_o` is low, every byte of the store is 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Hard-wired device address bits |
| wr_busy_i | input | 1 | Page-write unit is busy with an internal write |
| sda_low_o | output | 1 | Pull the data line low (open-drain enable) |
| wr_valid_o | output | 1 | One-cycle strobe for a stored byte |
| wr_addr_o | output | 8 | Address of the stored byte |
| wr_data_o | output | 8 | Value of the stored byte |

## Verification
A state machine that goes wrong shows up on the data line within one byte. A missing or extra acknowledge is visible at the ninth clock of the byte that triggered it. A corrupted word pointer cannot be seen while it is being loaded. It shows at the write strobe address of the next stored byte, or in the first byte returned by the next read, even when that read happens several transactions later. Wrap errors at a page edge or at address 255 appear only when a burst crosses that edge, so bursts are aimed at those boundaries.

// File: rtl/twi_tgt_pkg.sv
// Shared constants and state encoding for the two-wire memory target.
// Assumes byte-wide transfers and a one-byte word address.
package twi_tgt_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 8;
    localparam int CNT_W      = $clog2(BYTE_W) + 1;
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,   // ignoring bus until start
        ST_DEV,    // shifting in device address
        ST_DAK,    // acknowledging device address
        ST_WADR,   // shifting in word address
        ST_AAK,    // acknowledging word address
        ST_WDAT,   // shifting in write data
        ST_WDK,    // acknowledging write data
        ST_RDAT,   // shifting out read data
        ST_RACK    // sampling host acknowledge
    } tgt_state_e;
endpackage

// File: rtl/twi_line_sync.sv
// Synchronizes the bus clock and data lines into the system clock domain
// and derives clock edges and start/stop events from the synchronized samples.
// Assumes the bus is idle-high and slower than a few system clocks per phase.
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Shift both lines through the synchronizer chain and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    // Decode edges and bus conditions from the current and delayed samples.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_evt = scl_s & scl_q & sda_q & ~sda_s;
        stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/twi_word_ptr.sv
// Word pointer shared by all transactions. It loads from the address phase,
// steps with full wrap on reads and with in-page wrap on writes.
// Assumes load and the two step requests are never raised together.
module twi_word_ptr #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_rd,
    input  logic              step_wr,
    output logic [ADDR_W-1:0] ptr
);
    logic [PAGE_W-1:0] low_next;

    // Next in-page offset for a write step.
    always_comb low_next = ptr[PAGE_W-1:0] + 1'b1;

    // Update the pointer according to the requested action.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (step_rd)
            ptr <= ptr + 1'b1;
        else if (step_wr)
            ptr <= {ptr[ADDR_W-1:PAGE_W], low_next};
    end
endmodule

// File: rtl/twi_mem_array.sv
// Flip-flop byte store with one synchronous write port and one
// combinational read port. Cleared to zero by reset.
module twi_mem_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Clear on reset, otherwise write the addressed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Asynchronous read of the addressed byte.
    always_comb rdata = store[raddr];
endmodule

// File: rtl/twi_mem_target.sv
// Two-wire serial target in front of a byte store. It decodes the device
// address against a fixed prefix and strap bits, runs byte/page writes and
// current/random/sequential reads, and refuses addresses while busy.
// Assumes the bus clock phases last at least four system clocks.
module twi_mem_target
    import twi_tgt_pkg::*;
#(
    parameter int PAGE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    input  logic              wr_busy_i,
    output logic              sda_low_o,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    tgt_state_e        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              is_read;
    logic              host_ack;
    logic              byte_done;
    logic              dev_hit;
    logic              ptr_load, step_rd, step_wr;
    logic [ADDR_W-1:0] ptr;
    logic [BYTE_W-1:0] rd_byte;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    twi_word_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (rx_sh[ADDR_W-1:0]),
        .step_rd  (step_rd),
        .step_wr  (step_wr),
        .ptr      (ptr)
    );

    twi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (step_wr),
        .waddr (ptr),
        .wdata (rx_sh),
        .raddr (ptr),
        .rdata (rd_byte)
    );

    // Byte boundary and address decode, gated off on bus conditions.
    always_comb begin
        byte_done = scl_fall && (bit_cnt == LAST_BIT) && !start_evt && !stop_evt;
        dev_hit   = (rx_sh[7:4] == DEV_PREFIX) && (rx_sh[3:1] == strap_i) && !wr_busy_i;
        ptr_load  = byte_done && (state == ST_WADR);
        step_wr   = byte_done && (state == ST_WDAT);
        step_rd   = byte_done && (state == ST_RDAT);
    end

    // Protocol state machine: shifting, acknowledge drive and read data drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            is_read  <= 1'b0;
            host_ack <= 1'b0;
            sda_low_o <= 1'b0;
        end else if (start_evt) begin
            state     <= ST_DEV;
            bit_cnt   <= '0;
            sda_low_o <= 1'b0;
        end else if (stop_evt) begin
            state     <= ST_IDLE;
            sda_low_o <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_WADR, ST_WDAT: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_done) begin
                        if (state == ST_DEV) begin
                            if (dev_hit) begin
                                state     <= ST_DAK;
                                sda_low_o <= 1'b1;
                                is_read   <= rx_sh[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            state     <= (state == ST_WADR) ? ST_AAK : ST_WDK;
                            sda_low_o <= 1'b1;
                        end
                    end
                end
                ST_DAK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (is_read) begin
                            state     <= ST_RDAT;
                            tx_sh     <= rd_byte;
                            sda_low_o <= ~rd_byte[BYTE_W-1];
                        end else begin
                            state     <= ST_WADR;
                            sda_low_o <= 1'b0;
                        end
                    end
                end
                ST_AAK, ST_WDK: begin
                    if (scl_fall) begin
                        state     <= ST_WDAT;
                        bit_cnt   <= '0;
                        sda_low_o <= 1'b0;
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_done) begin
                        state     <= ST_RACK;
                        sda_low_o <= 1'b0;
                    end else if (scl_fall) begin
                        tx_sh     <= {tx_sh[BYTE_W-2:0], 1'b0};
                        sda_low_o <= ~tx_sh[BYTE_W-2];
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        bit_cnt <= '0;
                        if (host_ack) begin
                            state     <= ST_RDAT;
                            tx_sh     <= rd_byte;
                            sda_low_o <= ~rd_byte[BYTE_W-1];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Register the byte-write strobe toward the page-write unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid_o <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
        end else begin
            wr_valid_o <= step_wr;
            if (step_wr) begin
                wr_addr_o <= ptr;
                wr_data_o <= rx_sh;
            end
        end
    end
endmodule

// File: rtl/twi_mem_target_chk.sv
// Protocol checker for the two-wire memory target, attached by bind.
// Observes ports and the synchronizer/state nets of the target.
module twi_mem_target_chk
    import twi_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_evt,
    input logic       stop_evt,
    input logic [2:0] strap_i,
    input logic       wr_busy_i,
    input logic       sda_low_o,
    input logic       wr_valid_o,
    input tgt_state_e state,
    input logic [7:0] rx_sh
);
    // R1
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_low_o);

    // R2
    dev_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DAK && $past(state) != ST_DAK) |->
        ($past(rx_sh[7:4]) == DEV_PREFIX && $past(rx_sh[3:1]) == $past(strap_i)));

    // R3
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DAK && $past(state) != ST_DAK) |-> !$past(wr_busy_i));

    // R4
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |=> !wr_valid_o);

    // R6
    drive_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low_o) |-> (!scl_s || $past(start_evt) || $past(stop_evt)));
endmodule

bind twi_mem_target twi_mem_target_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .strap_i    (strap_i),
    .wr_busy_i  (wr_busy_i),
    .sda_low_o  (sda_low_o),
    .wr_valid_o (wr_valid_o),
    .state      (state),
    .rx_sh      (rx_sh)
);

// File: tb/twi_mem_target_tb.sv
// Bench for the two-wire memory target: a host model drives the bus,
// a reference byte store and pointer predict every acknowledge and byte.
module twi_mem_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;
    localparam logic [2:0] STRAP = 3'b101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic       wr_busy = 1'b0;
    logic       sda_low, wr_valid;
    logic [7:0] wr_addr, wr_data;
    wire        sda_line = sda_h & ~sda_low;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;
    logic [7:0] ref_mem [256];
    logic [7:0] ref_ptr;
    logic [7:0] last_wa, last_wd;
    int   wr_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_mem_target u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_h),
        .sda_i      (sda_line),
        .strap_i    (STRAP),
        .wr_busy_i  (wr_busy),
        .sda_low_o  (sda_low),
        .wr_valid_o (wr_valid),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data)
    );

    // Capture write strobes away from the active edge.
    always @(negedge clk) begin
        if (wr_valid) begin
            last_wa = wr_addr;
            last_wd = wr_data;
            wr_seen++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        wq(); sda_h = 1'b1; wq(); scl_h = 1'b1; wq(); sda_h = 1'b0; wq(); scl_h = 1'b0;
    endtask

    task automatic bus_stop();
        wq(); sda_h = 1'b0; wq(); scl_h = 1'b1; wq(); sda_h = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            wq(); sda_h = b[i]; wq(); scl_h = 1'b1; wq(); wq(); scl_h = 1'b0;
        end
        wq(); sda_h = 1'b1; wq(); scl_h = 1'b1; wq(); acked = ~sda_line; wq(); scl_h = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wq(); sda_h = 1'b1; wq(); scl_h = 1'b1; wq(); b[i] = sda_line; wq(); scl_h = 1'b0;
        end
        wq(); sda_h = ~give_ack; wq(); scl_h = 1'b1; wq(); wq(); scl_h = 1'b0;
    endtask

    function automatic logic [7:0] dev_byte(input logic [2:0] strap, input bit rd);
        return {4'b1010, strap, rd};
    endfunction

    function automatic logic [7:0] page_step(input logic [7:0] a);
        return {a[7:3], a[2:0] + 3'd1};
    endfunction

    // Write n bytes from addr; n == 0 only loads the pointer.
    task automatic do_write(input logic [7:0] addr, input int n, input bit end_stop);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte(dev_byte(STRAP, 1'b0), ack);
        check(ack, "R2 write address ack", ack, 1);
        send_byte(addr, ack);
        check(ack, "R4 word address ack", ack, 1);
        ref_ptr = addr;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, ack);
            check(ack, "R4 data ack", ack, 1);
            check(last_wa == ref_ptr, "R5 strobe address", last_wa, ref_ptr);
            check(last_wd == d, "R4 strobe data", last_wd, d);
            ref_mem[ref_ptr] = d;
            ref_ptr = page_step(ref_ptr);
        end
        if (end_stop) bus_stop();
    endtask

    // Read n bytes from the current pointer, after a start already issued.
    task automatic read_body(input int n, input string req);
        bit ack;
        logic [7:0] d;
        send_byte(dev_byte(STRAP, 1'b1), ack);
        check(ack, "R2 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, d);
            check(d == ref_mem[ref_ptr], req, d, ref_mem[ref_ptr]);
            ref_ptr = ref_ptr + 8'd1;
        end
        check(!sda_low, "R6 released after nack", sda_low, 0);
        bus_stop();
    endtask

    task automatic random_read(input logic [7:0] addr, input int n, input string req);
        do_write(addr, 0, 1'b0);
        bus_start();
        read_body(n, req);
    endtask

    task automatic current_read(input int n, input string req);
        bus_start();
        read_body(n, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        bit ack;
        void'($urandom(32'd20240918));
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
        ref_ptr = 8'h00;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        wq();
        // R10 reset state
        check(!sda_low, "R10 line released", sda_low, 0);
        check(!wr_valid, "R10 no strobe", wr_valid, 0);
        current_read(2, "R10 cleared store from pointer 0");
        check(ref_ptr == 8'd2, "R8 pointer model", ref_ptr, 2);

        // R1 byte without a start is ignored
        send_byte(dev_byte(STRAP, 1'b0), ack);
        check(!ack, "R1 no ack without start", ack, 0);
        bus_stop();

        // R2 wrong prefix and wrong strap
        bus_start();
        send_byte({4'b1011, STRAP, 1'b0}, ack);
        check(!ack, "R2 wrong prefix nack", ack, 0);
        bus_stop();
        bus_start();
        send_byte(dev_byte(STRAP ^ 3'b010, 1'b1), ack);
        check(!ack, "R2 wrong strap nack", ack, 0);
        check(!sda_low, "R2 line stays released", sda_low, 0);
        bus_stop();

        // R3 busy refuses, then accepts
        wr_busy = 1'b1;
        bus_start();
        send_byte(dev_byte(STRAP, 1'b0), ack);
        check(!ack, "R3 busy nack", ack, 0);
        bus_stop();
        wr_busy = 1'b0;

        // R4 R5 page write crossing the page edge
        do_write(8'h1E, 10, 1'b1);
        check(ref_ptr == 8'h18, "R5 pointer model", ref_ptr, 8'h18);
        // R8 current read picks up after the write
        current_read(3, "R8 current address read");
        // R9 random read of the wrapped page
        random_read(8'h18, 8, "R9 random read");
        // R7 read wraps 255 to 0
        do_write(8'hFE, 2, 1'b1);
        random_read(8'hFE, 4, "R7 read wrap");
        // R6 single-byte read and sequential read
        random_read(8'h1F, 1, "R6 single byte");

        // Mixed random traffic
        for (int t = 0; t < 24; t++) begin
            int kind = int'($urandom_range(0, 2));
            logic [7:0] a = 8'($urandom);
            int n = int'($urandom_range(1, 10));
            if (kind == 0) do_write(a, n, 1'b1);
            else if (kind == 1) random_read(a, n, "R6 sequential read");
            else current_read(n, "R8 current read random");
        end
        finish_run();
    end
endmodule